// File: doc/BRIEF.md
# Parallel Pattern Source and Response Signature Pair

This block supplies stimulus to, and compacts responses from, 61 parallel scan channels during logic self-test. A 61-stage linear-feedback generator advances once per shift cycle. Its state passes through an XOR spreading stage that yields one stimulus bit per channel. On the same shift cycle, a 61-stage multiple-input signature register folds in one response bit from each channel. The responses of the previous pattern are therefore compacted while the next pattern is being loaded.

Before a test starts, both registers are loaded with programmed seeds. When neither a load nor a shift is requested, both registers keep their contents. A controller pulses a final-pattern indication at the end of the test. The block then compares the finished signature with an expected value and reports the result as a registered pass flag, qualified by a valid flag. A generator seed of all zeros would lock the generator, so the block raises an error flag when such a seed is loaded.

Top module: `stp_pair_top`

## Requirements
- R1: After reset, `chan_stim`, `signature`, `seed_zero_err`, `sig_valid` and `sig_pass` are all zero.
- R2: On a clock edge where `seed_load` is 1, the generator takes `gen_seed` and the signature register takes `sig_seed`. This happens even when `shift_en` is also 1.
- R3: On a clock edge with `shift_en`=1 and `seed_load`=0, generator stage i (i<60) takes stage i+1. Stage 60 takes the XOR of stages 0, 14, 15 and 60.
- R4: `chan_stim[0]` equals generator stage 0. For every i from 1 to 60, `chan_stim[i]` equals generator stage i XOR generator stage 0.
- R5: On a shift edge, signature bit i (i<60) takes bit i+1 XOR `chan_resp[i]`. Bit 60 takes the XOR of signature bits 0, 14, 15 and 60, then XOR `chan_resp[60]`.
- R6: With `seed_load`=0 and `shift_en`=0, the generator and the signature keep their values, whatever `chan_resp` carries.
- R7: On a seed-load edge, `seed_zero_err` is set if `gen_seed` is all zeros and cleared otherwise. It holds its value between loads.
- R8: `sig_valid` is 0 in the cycle after the edge that samples `final_pat`=1, and becomes 1 one edge later. A seed load clears it.
- R9: When `sig_valid` rises, `sig_pass` is 1 exactly when all 61 signature bits equal `sig_expect`. A single differing bit gives 0. `sig_pass` is never 1 while `sig_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load | input | 1 | Load both seeds (takes priority over shift) |
| shift_en | input | 1 | Advance generator and absorb channel responses |
| gen_seed | input | 61 | Seed for the generator |
| sig_seed | input | 61 | Seed for the signature register |
| chan_resp | input | 61 | Scan outputs of the 61 channels |
| final_pat | input | 1 | End-of-test indication from the controller |
| sig_expect | input | 61 | Precomputed good signature |
| chan_stim | output | 61 | Spread stimulus to the channel scan inputs |
| signature | output | 61 | Current signature register contents |
| seed_zero_err | output | 1 | Generator was seeded with all zeros |
| sig_valid | output | 1 | Compare result is available |
| sig_pass | output | 1 | Signature matched the expected value |

## Verification
On every cycle, the assertions check the following: seed capture and its priority over shift, holding when idle, the shift direction of both registers including the response folding, the zero-seed flag, that pass is never raised without valid, and that valid only rises two edges after a final indication. Only the bench scenarios can show the exact feedback value entering stage 60 over long random runs. The same holds for the full-width spreading pattern, and for the compare giving the right verdict for a matching signature and for a signature with one flipped bit. The bench recovers the generator state from the spread outputs, so the generator sequence is checked at the ports.

// File: rtl/stp_pkg.sv
package stp_pkg;

  // Default register length and feedback stages of the polynomial.
  localparam int DEF_W    = 61;
  localparam int DEF_TAPA = 0;
  localparam int DEF_TAPB = 14;
  localparam int DEF_TAPC = 15;
  localparam int DEF_TAPD = 60;

  // Progress of the end-of-test compare.
  typedef enum logic [1:0] {
    CMP_IDLE = 2'd0,
    CMP_PEND = 2'd1,
    CMP_DONE = 2'd2
  } cmp_state_e;

endpackage

// File: rtl/stp_rst_sync.sv
module stp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  // Assertion is immediate; release walks through the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/stp_pattern_gen.sv
module stp_pattern_gen #(
  parameter int W    = stp_pkg::DEF_W,
  parameter int TAPA = stp_pkg::DEF_TAPA,
  parameter int TAPB = stp_pkg::DEF_TAPB,
  parameter int TAPC = stp_pkg::DEF_TAPC,
  parameter int TAPD = stp_pkg::DEF_TAPD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic         shift_en,
  input  logic [W-1:0] gen_seed,
  output logic [W-1:0] chan_stim,
  output logic         seed_zero_err
);

  localparam int TOP = W - 1;

  logic [W-1:0] gen_q;
  logic [W-1:0] gen_d;
  logic         gen_en;
  logic         feed_bit;
  logic         err_q;
  logic         err_d;

  // Next-state: load has priority; shift moves toward stage 0.
  always_comb begin
    feed_bit = gen_q[TAPA] ^ gen_q[TAPB] ^ gen_q[TAPC] ^ gen_q[TAPD];
    gen_en   = seed_load | shift_en;
    if (seed_load) begin
      gen_d = gen_seed;
    end else begin
      gen_d = {feed_bit, gen_q[TOP:1]};
    end
    err_d = err_q;
    if (seed_load) begin
      err_d = (gen_seed == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (gen_en) begin
        gen_q <= gen_d;
      end
      if (seed_load) begin
        err_q <= err_d;
      end
    end
  end

  // Spreading stage: channel 0 is stage 0 alone, others mix in stage 0.
  generate
    for (genvar ch = 0; ch < W; ch++) begin : g_spread
      if (ch == 0) begin : g_direct
        assign chan_stim[ch] = gen_q[0];
      end else begin : g_mixed
        assign chan_stim[ch] = gen_q[ch] ^ gen_q[0];
      end
    end
  endgenerate

  assign seed_zero_err = err_q;

  AST_GEN_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (gen_q == $past(gen_seed))) else $error("gen seed"); // R2

  AST_GEN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !shift_en) |=> $stable(gen_q)) else $error("gen hold"); // R6

  AST_GEN_SHIFT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !seed_load) |=> (gen_q[TOP-1:0] == $past(gen_q[TOP:1])))
    else $error("gen shift"); // R3

  AST_ZERO_SEED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (seed_zero_err == ($past(gen_seed) == '0)))
    else $error("zero seed flag"); // R7

  AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> $stable(seed_zero_err)) else $error("flag moved"); // R7

endmodule

// File: rtl/stp_sig_reg.sv
module stp_sig_reg #(
  parameter int W    = stp_pkg::DEF_W,
  parameter int TAPA = stp_pkg::DEF_TAPA,
  parameter int TAPB = stp_pkg::DEF_TAPB,
  parameter int TAPC = stp_pkg::DEF_TAPC,
  parameter int TAPD = stp_pkg::DEF_TAPD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic         shift_en,
  input  logic [W-1:0] sig_seed,
  input  logic [W-1:0] chan_resp,
  output logic [W-1:0] signature
);

  localparam int TOP = W - 1;

  logic [W-1:0] sig_q;
  logic [W-1:0] sig_d;
  logic [W-1:0] shifted;
  logic         sig_en;
  logic         feed_bit;

  always_comb begin
    feed_bit = sig_q[TAPA] ^ sig_q[TAPB] ^ sig_q[TAPC] ^ sig_q[TAPD];
    sig_en   = seed_load | shift_en;
  end

  // One response bit folded in ahead of each stage.
  generate
    for (genvar st = 0; st < W; st++) begin : g_fold
      if (st == TOP) begin : g_head
        assign shifted[st] = feed_bit ^ chan_resp[st];
      end else begin : g_body
        assign shifted[st] = sig_q[st+1] ^ chan_resp[st];
      end
    end
  endgenerate

  always_comb begin
    if (seed_load) begin
      sig_d = sig_seed;
    end else begin
      sig_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q <= '0;
    end else if (sig_en) begin
      sig_q <= sig_d;
    end
  end

  assign signature = sig_q;

  AST_SIG_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (signature == $past(sig_seed))) else $error("sig seed"); // R2

  AST_SIG_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !shift_en) |=> $stable(signature)) else $error("sig hold"); // R6

  AST_SIG_ABSORB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !seed_load) |=>
      (signature[TOP-1:0] == ($past(signature[TOP:1]) ^ $past(chan_resp[TOP-1:0]))))
    else $error("sig absorb"); // R5

endmodule

// File: rtl/stp_sig_cmp.sv
module stp_sig_cmp #(
  parameter int W = stp_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic         final_pat,
  input  logic [W-1:0] signature,
  input  logic [W-1:0] sig_expect,
  output logic         sig_valid,
  output logic         sig_pass
);

  import stp_pkg::*;

  cmp_state_e st_q;
  cmp_state_e st_d;
  logic       pass_q;
  logic       pass_d;
  logic       pass_en;

  always_comb begin
    st_d    = st_q;
    pass_d  = pass_q;
    pass_en = 1'b0;
    if (seed_load) begin
      st_d    = CMP_IDLE;
      pass_d  = 1'b0;
      pass_en = 1'b1;
    end else if (final_pat) begin
      st_d    = CMP_PEND;
      pass_d  = 1'b0;
      pass_en = 1'b1;
    end else if (st_q == CMP_PEND) begin
      st_d    = CMP_DONE;
      pass_d  = (signature == sig_expect);
      pass_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CMP_IDLE;
      pass_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (pass_en) begin
        pass_q <= pass_d;
      end
    end
  end

  assign sig_valid = (st_q == CMP_DONE);
  assign sig_pass  = pass_q;

  AST_PASS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sig_pass |-> sig_valid) else $error("pass without valid"); // R9

  AST_VALID_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_valid) |-> $past(final_pat, 2)) else $error("valid timing"); // R8

  AST_LOAD_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> !sig_valid) else $error("valid after load"); // R8

endmodule

// File: rtl/stp_pair_top.sv
module stp_pair_top #(
  parameter int W    = stp_pkg::DEF_W,
  parameter int TAPA = stp_pkg::DEF_TAPA,
  parameter int TAPB = stp_pkg::DEF_TAPB,
  parameter int TAPC = stp_pkg::DEF_TAPC,
  parameter int TAPD = stp_pkg::DEF_TAPD,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seed_load,
  input  logic         shift_en,
  input  logic [W-1:0] gen_seed,
  input  logic [W-1:0] sig_seed,
  input  logic [W-1:0] chan_resp,
  input  logic         final_pat,
  input  logic [W-1:0] sig_expect,
  output logic [W-1:0] chan_stim,
  output logic [W-1:0] signature,
  output logic         seed_zero_err,
  output logic         sig_valid,
  output logic         sig_pass
);

  logic rst_n_s;

  stp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  stp_pattern_gen #(
    .W(W), .TAPA(TAPA), .TAPB(TAPB), .TAPC(TAPC), .TAPD(TAPD)
  ) u_gen (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .seed_load     (seed_load),
    .shift_en      (shift_en),
    .gen_seed      (gen_seed),
    .chan_stim     (chan_stim),
    .seed_zero_err (seed_zero_err)
  );

  stp_sig_reg #(
    .W(W), .TAPA(TAPA), .TAPB(TAPB), .TAPC(TAPC), .TAPD(TAPD)
  ) u_sig (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .seed_load (seed_load),
    .shift_en  (shift_en),
    .sig_seed  (sig_seed),
    .chan_resp (chan_resp),
    .signature (signature)
  );

  stp_sig_cmp #(.W(W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .seed_load  (seed_load),
    .final_pat  (final_pat),
    .signature  (signature),
    .sig_expect (sig_expect),
    .sig_valid  (sig_valid),
    .sig_pass   (sig_pass)
  );

endmodule

// File: tb/tb_stp_pair_top.sv
`timescale 1ns/1ps
module tb_stp_pair_top;

  localparam int W = 61;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         seed_load, shift_en, final_pat;
  logic [W-1:0] gen_seed, sig_seed, chan_resp, sig_expect;
  logic [W-1:0] chan_stim, signature;
  logic         seed_zero_err, sig_valid, sig_pass;

  int n_chk  = 0;
  int n_fail = 0;
  logic [W-1:0] m_gen, m_sig;

  always #5 clk = ~clk;

  stp_pair_top dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .shift_en(shift_en),
    .gen_seed(gen_seed), .sig_seed(sig_seed), .chan_resp(chan_resp),
    .final_pat(final_pat), .sig_expect(sig_expect), .chan_stim(chan_stim),
    .signature(signature), .seed_zero_err(seed_zero_err),
    .sig_valid(sig_valid), .sig_pass(sig_pass)
  );

  function automatic logic [W-1:0] gen_next(input logic [W-1:0] s);
    logic fb = s[0] ^ s[14] ^ s[15] ^ s[60];
    return {fb, s[W-1:1]};
  endfunction

  function automatic logic [W-1:0] sig_next(input logic [W-1:0] m, input logic [W-1:0] r);
    logic fb = m[0] ^ m[14] ^ m[15] ^ m[60];
    return {fb, m[W-1:1]} ^ r;
  endfunction

  function automatic logic [W-1:0] spread(input logic [W-1:0] s);
    logic [W-1:0] o = s ^ {W{s[0]}};
    o[0] = s[0];
    return o;
  endfunction

  function automatic logic [W-1:0] unspread(input logic [W-1:0] o);
    logic [W-1:0] s = o ^ {W{o[0]}};
    s[0] = o[0];
    return s;
  endfunction

  function automatic logic [W-1:0] rnd61();
    logic [63:0] t = {$urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Applies current inputs for one edge and advances the bench model.
  task automatic step();
    if (seed_load) begin
      m_gen = gen_seed;
      m_sig = sig_seed;
    end else if (shift_en) begin
      m_gen = gen_next(m_gen);
      m_sig = sig_next(m_sig, chan_resp);
    end
    tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; seed_load = 0; shift_en = 0; final_pat = 0;
    gen_seed = '0; sig_seed = '0; chan_resp = '0; sig_expect = '0;
    m_gen = '0; m_sig = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(chan_stim == '0, "R1 stim", chan_stim, '0);
    chk(signature == '0, "R1 sig", signature, '0);
    chk({seed_zero_err, sig_valid, sig_pass} == 3'b000, "R1 flags",
        {58'd0, seed_zero_err, sig_valid, sig_pass}, '0);

    // R7: all-zero generator seed raises the flag
    seed_load = 1; gen_seed = '0; sig_seed = rnd61();
    step();
    seed_load = 0;
    chk(seed_zero_err == 1'b1, "R7 zero seed", {60'd0, seed_zero_err}, 1);
    chk(signature == m_sig, "R2 sig seed", signature, m_sig);

    // R2: load wins over a simultaneous shift; R7 flag clears
    seed_load = 1; shift_en = 1; gen_seed = rnd61() | 61'd1; sig_seed = rnd61();
    step();
    seed_load = 0; shift_en = 0;
    chk(unspread(chan_stim) == m_gen, "R2 gen seed priority", unspread(chan_stim), m_gen);
    chk(signature == m_sig, "R2 sig seed priority", signature, m_sig);
    chk(seed_zero_err == 1'b0, "R7 nonzero seed", {60'd0, seed_zero_err}, 0);

    // R6: idle cycles with busy responses change nothing
    for (int k = 0; k < 3; k++) begin
      chan_resp = rnd61();
      step();
      chk(signature == m_sig, "R6 sig hold", signature, m_sig);
      chk(unspread(chan_stim) == m_gen, "R6 gen hold", unspread(chan_stim), m_gen);
    end

    // R3 R4 R5: random shifting with random responses
    for (int k = 0; k < 300; k++) begin
      shift_en  = ($urandom() % 4) != 0;
      chan_resp = rnd61();
      step();
      chk(chan_stim == spread(m_gen), "R4 spread", chan_stim, spread(m_gen));
      chk(unspread(chan_stim) == m_gen, "R3 generator step", unspread(chan_stim), m_gen);
      chk(signature == m_sig, "R5 signature", signature, m_sig);
      chk(seed_zero_err == 1'b0, "R7 held", {60'd0, seed_zero_err}, 0);
    end
    shift_en = 0; chan_resp = '0;

    // R3: directed feedback from a single set stage 14
    seed_load = 1; gen_seed = 61'd1 << 14; sig_seed = '1;
    step();
    seed_load = 0; shift_en = 1; chan_resp = '1;
    step();
    shift_en = 0; chan_resp = '0;
    chk(unspread(chan_stim) == ((61'd1 << 60) | (61'd1 << 13)), "R3 tap feedback",
        unspread(chan_stim), (61'd1 << 60) | (61'd1 << 13));
    chk(signature == m_sig, "R5 all ones", signature, m_sig);

    // R8 R9: matching compare
    sig_expect = m_sig;
    final_pat = 1;
    step();
    final_pat = 0;
    chk(sig_valid == 1'b0, "R8 valid not yet", {60'd0, sig_valid}, 0);
    step();
    chk(sig_valid == 1'b1, "R8 valid rises", {60'd0, sig_valid}, 1);
    chk(sig_pass == 1'b1, "R9 match passes", {60'd0, sig_pass}, 1);

    // R8: seed load clears valid
    seed_load = 1; gen_seed = rnd61() | 61'd1; sig_seed = rnd61();
    step();
    seed_load = 0;
    chk(sig_valid == 1'b0, "R8 load clears", {60'd0, sig_valid}, 0);
    chk(sig_pass == 1'b0, "R9 pass low", {60'd0, sig_pass}, 0);

    for (int k = 0; k < 20; k++) begin
      shift_en = 1; chan_resp = rnd61();
      step();
    end
    shift_en = 0; chan_resp = '0;

    // R9: one flipped bit fails the compare
    sig_expect = m_sig ^ (61'd1 << ($urandom() % W));
    final_pat = 1;
    step();
    final_pat = 0;
    step();
    chk(sig_valid == 1'b1, "R8 valid second run", {60'd0, sig_valid}, 1);
    chk(sig_pass == 1'b0, "R9 mismatch fails", {60'd0, sig_pass}, 0);
    chk(signature == m_sig, "R6 sig held through compare", signature, m_sig);

    finish_run();
  end

endmodule